// File: doc/BRIEF.md
# Flow-Control Release Packet Scheduler

This block decides when the transmit path should slip a buffer-release NOP into the outgoing packet stream. It watches the packets that leave the link and counts the ordinary, non-release packets sent since the last release NOP went out. When the receive side has freed credits that still have to be announced, the block raises a request to the transmit mux.

On an idle link the request goes out in the same cycle that credits are pending. On a busy link the request is withheld until a programmable minimum number of ordinary packets have been sent since the previous release NOP. Release traffic therefore cannot crowd out payload bandwidth.

Once the request is raised it stays up until the transmit side acknowledges that the NOP was sent. The minimum spacing comes from a small configuration register that is written through a write strobe. Packet formatting and the mux itself live elsewhere.

Top module: `frs_release_sched`

## Requirements
- R1: After reset, `nop_req_o` is low while no credits are pending, the spacing register holds 4, and the packet counter starts saturated at 15, so the first release is never held back by spacing.
- R2: When `credit_pend_i` is high and `link_busy_i` is low, `nop_req_o` is high in that same cycle, whatever the counter value.
- R3: When the link is busy, a new request is raised only while the packet count is greater than or equal to the programmed spacing.
- R4: The counter goes to 0 on the clock edge where `nop_ack_i` is high. On an edge with `pkt_sent_i` high and no ack, it adds one. If ack and `pkt_sent_i` are both high on the same edge, the packet counts as sent after the NOP and the counter becomes 1.
- R5: The counter saturates at 15. Further packets without an ack leave it at 15.
- R6: A new request is raised only in a cycle where `credit_pend_i` is high. With no credits pending, `nop_req_o` stays low however many packets are sent.
- R7: Once `nop_req_o` is high it stays high on every following cycle until a clock edge with `nop_ack_i` high, even if credits drop or the link turns busy.
- R8: A spacing value of 0 lets release NOPs go out back to back on a busy link: the cycle after an ack, the request is high again if credits are still pending.
- R9: A write (`cfg_we_i` high) loads `cfg_spacing_i` into the spacing register on that clock edge. The new value governs the busy-link decision from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the spacing register |
| cfg_spacing_i | input | 4 | New minimum packet spacing |
| credit_pend_i | input | 1 | Freed credits are waiting to be announced |
| link_busy_i | input | 1 | Payload traffic is queued for the link |
| pkt_sent_i | input | 1 | One non-release packet left the link this cycle |
| nop_ack_i | input | 1 | The transmit mux sent the release NOP this cycle |
| nop_req_o | output | 1 | Request to send a release NOP |

## Verification
The counter can be cleared by a release acknowledge and advanced by an ordinary packet on the same edge. The bench drives both strobes together on a busy link with spacing 1. The request must then reappear in the very next cycle, because the count is 1 and not 0. A behavioural model in the bench, built from integers, tracks the counter, the spacing and the held request. Its predicted request is compared with `nop_req_o` on every cycle, including this collision and a collision between a spacing write and a packet strobe.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int unsigned SPC_W     = 4;
  localparam int unsigned SPC_RESET = 4;
endpackage

// File: rtl/frs_cfg_reg.sv
module frs_cfg_reg #(
  parameter int unsigned W     = 4,
  parameter int unsigned RST_V = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] spacing_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   spacing_o <= W'(RST_V);
    else if (we_i) spacing_o <= wdata_i;
  end
endmodule

// File: rtl/frs_pkt_counter.sv
module frs_pkt_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= MAX;
    else if (clr_i)               cnt_o <= inc_i ? W'(1) : '0; // packet after the NOP
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/frs_req_ctrl.sv
module frs_req_ctrl #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         credit_i,
  input  logic         busy_i,
  input  logic         ack_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] spacing_i,
  output logic         req_o
);
  logic eligible;
  logic hold_q;

  assign eligible = credit_i && (!busy_i || (cnt_i >= spacing_i));
  assign req_o    = hold_q || eligible;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= req_o && !ack_i;
  end
endmodule

// File: rtl/frs_release_sched.sv
module frs_release_sched #(
  parameter int unsigned SPACE_W   = frs_pkg::SPC_W,
  parameter int unsigned SPACE_RST = frs_pkg::SPC_RESET
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SPACE_W-1:0] cfg_spacing_i,
  input  logic               credit_pend_i,
  input  logic               link_busy_i,
  input  logic               pkt_sent_i,
  input  logic               nop_ack_i,
  output logic               nop_req_o
);
  logic [SPACE_W-1:0] spacing_q;
  logic [SPACE_W-1:0] cnt_q;

  frs_cfg_reg #(.W(SPACE_W), .RST_V(SPACE_RST)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_spacing_i),
    .spacing_o (spacing_q)
  );

  frs_pkt_counter #(.W(SPACE_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (nop_ack_i),
    .inc_i  (pkt_sent_i),
    .cnt_o  (cnt_q)
  );

  frs_req_ctrl #(.W(SPACE_W)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .credit_i  (credit_pend_i),
    .busy_i    (link_busy_i),
    .ack_i     (nop_ack_i),
    .cnt_i     (cnt_q),
    .spacing_i (spacing_q),
    .req_o     (nop_req_o)
  );
endmodule

// File: rtl/frs_release_sched_chk.sv
module frs_release_sched_chk #(
  parameter int unsigned SPACE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               credit_pend_i,
  input logic               link_busy_i,
  input logic               pkt_sent_i,
  input logic               nop_ack_i,
  input logic               nop_req_o,
  input logic [SPACE_W-1:0] cnt_i,
  input logic [SPACE_W-1:0] spacing_i
);
  localparam logic [SPACE_W-1:0] MAX = {SPACE_W{1'b1}};

  AST_IDLE_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_pend_i && !link_busy_i) |-> nop_req_o); // R2

  AST_BUSY_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(nop_req_o) && link_busy_i) |-> (cnt_i >= spacing_i)); // R3

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nop_ack_i && !pkt_sent_i) |=> (cnt_i == '0)); // R4

  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i == MAX) && !nop_ack_i) |=> (cnt_i == MAX)); // R5

  AST_REQ_NEEDS_CREDIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nop_req_o) |-> credit_pend_i); // R6

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nop_req_o && !nop_ack_i) |=> nop_req_o); // R7
endmodule

bind frs_release_sched frs_release_sched_chk #(.SPACE_W(SPACE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .credit_pend_i (credit_pend_i),
  .link_busy_i   (link_busy_i),
  .pkt_sent_i    (pkt_sent_i),
  .nop_ack_i     (nop_ack_i),
  .nop_req_o     (nop_req_o),
  .cnt_i         (cnt_q),
  .spacing_i     (spacing_q)
);

// File: tb/frs_release_sched_tb.sv
`timescale 1ns/1ps
module frs_release_sched_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [3:0] cfg_spacing_i = '0;
  logic       credit_pend_i = 1'b0;
  logic       link_busy_i = 1'b0;
  logic       pkt_sent_i = 1'b0;
  logic       nop_ack_i = 1'b0;
  logic       nop_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int  m_cnt = 15;
  int  m_spc = 4;
  bit  m_hold = 1'b0;

  always #10 clk_i = ~clk_i;

  frs_release_sched u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_spacing_i (cfg_spacing_i),
    .credit_pend_i (credit_pend_i),
    .link_busy_i   (link_busy_i),
    .pkt_sent_i    (pkt_sent_i),
    .nop_ack_i     (nop_ack_i),
    .nop_req_o     (nop_req_o)
  );

  function automatic bit model_req(bit cr, bit busy);
    return m_hold || (cr && (!busy || m_cnt >= m_spc));
  endfunction

  task automatic step(input bit cr, input bit busy, input bit pkt, input bit ack,
                      input bit we, input int wd, input string tag);
    bit exp;
    @(negedge clk_i);
    credit_pend_i = cr; link_busy_i = busy; pkt_sent_i = pkt;
    nop_ack_i = ack; cfg_we_i = we; cfg_spacing_i = 4'(wd);
    #2;
    exp = model_req(cr, busy);
    checks++;
    if (nop_req_o !== exp) begin
      errors++;
      $display("FAIL %s t=%0t nop_req_o actual=%b expected=%b", tag, $time, nop_req_o, exp);
    end
    @(posedge clk_i);
    if (we) m_spc = wd;
    if (ack) m_cnt = pkt ? 1 : 0;
    else if (pkt && m_cnt < 15) m_cnt++;
    m_hold = exp && !ack;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #45 rst_ni = 1'b1;
    // R1: reset state, then saturated counter lets busy request through at default spacing
    step(0, 1, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 0, 0, 0, 0, "R1");
    step(1, 1, 0, 1, 0, 0, "R1");
    // R3: busy, default spacing 4 needs four packets
    for (int i = 0; i < 6; i++) step(1, 1, (i < 4), 0, 0, 0, "R3");
    step(1, 1, 0, 1, 0, 0, "R3");
    // R2: idle link, immediate request regardless of count
    step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 1, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 1, 0, 0, "R2");
    // R7: request held while credits drop and link is busy
    step(1, 0, 0, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, 0, "R7");
    step(0, 1, 0, 1, 0, 0, "R7");
    step(0, 1, 0, 0, 0, 0, "R7");
    // R9/R8: write spacing 0, back-to-back on busy link
    step(1, 1, 0, 0, 1, 0, "R9");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 0, 0, "R8");
    // R4: ack and packet together with spacing 1
    step(0, 1, 0, 0, 1, 1, "R9");
    step(1, 1, 1, 1, 0, 0, "R4");
    step(1, 1, 0, 1, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 0, "R4");
    step(1, 1, 1, 0, 0, 0, "R4");
    step(1, 1, 0, 1, 0, 0, "R4");
    // R9: write coincident with packet strobe
    step(0, 1, 1, 0, 1, 15, "R9");
    step(1, 1, 0, 0, 0, 0, "R9");
    // R6/R5: no credits, many packets, no request; counter saturates
    step(0, 1, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 20; i++) step(0, 1, 1, 0, 0, 0, "R6");
    step(1, 1, 0, 0, 0, 0, "R5");
    step(1, 1, 1, 0, 0, 0, "R5");
    step(1, 1, 0, 1, 0, 0, "R5");
    // R3: spacing 15 needs fifteen packets
    for (int i = 0; i < 17; i++) step(1, 1, (i < 15), 0, 0, 0, "R3");
    step(1, 1, 0, 1, 0, 0, "R3");
    // mixed pattern
    for (int i = 0; i < 200; i++)
      step(((i * 7) % 5) != 0, ((i * 3) % 4) != 0, (i % 3) == 0, (i % 6) == 5,
           (i % 37) == 0, i % 16, "R3");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule